// File: doc/BRIEF.md
# Reset-Source and Supply Status Register

This block is one byte-wide control/status register for supply and clock health. It sits on a simple memory-mapped byte bus. Software can read whether the clock multiplier has locked, whether the most recent reset came from the low-voltage detector, and whether the supply is currently below the detector threshold. It can also enable an interrupt that fires when the supply drops below that threshold.

The bits live in different reset domains. The lock flag is cleared only by power-on reset. The low-voltage reset flag is set by a low-voltage reset and survives external and watchdog resets, so the original fault stays recorded. The interrupt enable and the pending request are cleared by every reset. The pending request clears when the CPU signals that it has entered the service routine, not through a register write.

The comparator and lock inputs are asynchronous. Each passes through a two-flop synchronizer before any flag or edge logic uses it.

Top module: `supply_status_reg`

## Requirements
- R1: Bits 7..4 of the register always read as 0, and writes to them change nothing.
- R2: Bit 3 (lock) becomes 1 on the third clock edge after the lock input goes high. It then stays 1 when the input falls, when software writes 0 to it, and across any system reset. Only power-on reset clears it.
- R3: A system reset with the low-voltage cause input high sets bit 2 (low-voltage reset flag). A system reset with that cause input low leaves bit 2 unchanged.
- R4: A bus write with data bit 2 = 0 clears bit 2. A write with data bit 2 = 1 leaves it as it was.
- R5: Bit 1 (supply low) reads as the comparator input delayed by two clock edges. It is 1 when the supply is below the threshold, and bus writes cannot change it.
- R6: Bit 0 (interrupt enable) takes data bit 0 of each bus write. Both power-on reset and system reset clear it to 0.
- R7: While bit 0 is 1, a 0-to-1 change of the synchronized supply-low flag drives irq_o high one clock edge later. While bit 0 is 0, such a change raises no request.
- R8: An acknowledge clears irq_o on the next edge. If an acknowledge and a new rising edge of the flag fall in the same cycle, the request stays pending.
- R9: A system reset of any cause drops irq_o on the next edge.
- R10: The register answers only at byte address 0x3A. Reads at any other address return 0, and writes there are ignored.
- R11: Power-on reset clears every bit of the register and the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| sys_rst_i | input | 1 | System reset of any non-power-on cause, synchronous, active high |
| rst_lvd_cause_i | input | 1 | High while sys_rst_i is caused by the low-voltage detector |
| pll_lock_raw_i | input | 1 | Asynchronous lock indication from the clock multiplier |
| vdet_low_raw_i | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| irq_ack_i | input | 1 | CPU entered the supply interrupt routine |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational, 0 when not addressed |
| irq_o | output | 1 | Pending supply-low interrupt request |

## Verification
Reset stimulus runs power-on, low-voltage, watchdog-like and external-like system resets in turn. This separates the lock bit, which only power-on reset clears, from the low-voltage reset flag, which only a low-voltage reset sets, and from the enable bit, which every reset clears. Directed pulses on the comparator input measure the two-edge read latency and the three-edge request latency. They also produce the case where an acknowledge and a new rising edge land in the same cycle, which tells edge priority apart from acknowledge priority. A seeded random stretch toggles the comparator and the acknowledge freely and compares the read bit and irq_o against a cycle model. This exposes off-by-one synchronizer depth and lost or doubled edges.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int unsigned BUS_AW      = 8;
    localparam int unsigned BUS_DW      = 8;
    localparam int unsigned SYNC_STAGES = 2;
    localparam logic [BUS_AW-1:0] STATUS_ADDR = 8'h3A;

    // bit positions within the status byte
    localparam int unsigned BIT_LOCK = 3;
    localparam int unsigned BIT_LVD  = 2;
    localparam int unsigned BIT_VDET = 1;
    localparam int unsigned BIT_IEN  = 0;

    typedef enum logic [1:0] {
        RST_NONE,
        RST_POWER,
        RST_SYS_LVD,
        RST_SYS_OTHER
    } rst_kind_e;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       pll_lock;
        logic       lvd_rst;
        logic       vdet_low;
        logic       irq_en;
    } status_t;

    typedef struct packed {
        logic hit;
        logic lvd_bit;
        logic ien_bit;
    } wr_req_t;

    function automatic rst_kind_e classify_reset(input logic por, input logic sys, input logic lvd);
        if (por)
            return RST_POWER;
        else if (sys)
            return lvd ? RST_SYS_LVD : RST_SYS_OTHER;
        else
            return RST_NONE;
    endfunction

    function automatic logic [BUS_DW-1:0] status_to_byte(input status_t s);
        logic [BUS_DW-1:0] b;
        b = '0;
        b[BIT_LOCK] = s.pll_lock;
        b[BIT_LVD]  = s.lvd_rst;
        b[BIT_VDET] = s.vdet_low;
        b[BIT_IEN]  = s.irq_en;
        return b;
    endfunction

endpackage

// File: rtl/ssr_sync_bank.sv
module ssr_sync_bank #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) chain[g] <= '0;
                else       chain[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) chain[g] <= '0;
                else       chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ssr_flag_bank.sv
module ssr_flag_bank
    import ssr_pkg::*;
(
    input  logic      clk_i,
    input  logic      por_i,
    input  rst_kind_e kind_i,
    input  logic      lock_s_i,
    input  wr_req_t   wr_i,
    output logic      lock_flag_o,
    output logic      lvd_flag_o,
    output logic      irq_en_o
);
    always_ff @(posedge clk_i) begin
        unique case (kind_i)
            RST_POWER: begin
                lock_flag_o <= 1'b0;
                lvd_flag_o  <= 1'b0;
                irq_en_o    <= 1'b0;
            end
            RST_SYS_LVD: begin
                lock_flag_o <= lock_flag_o | lock_s_i;
                lvd_flag_o  <= 1'b1;
                irq_en_o    <= 1'b0;
            end
            RST_SYS_OTHER: begin
                lock_flag_o <= lock_flag_o | lock_s_i;
                irq_en_o    <= 1'b0;
            end
            default: begin
                lock_flag_o <= lock_flag_o | lock_s_i;
                if (wr_i.hit) begin
                    if (!wr_i.lvd_bit) lvd_flag_o <= 1'b0;
                    irq_en_o <= wr_i.ien_bit;
                end
            end
        endcase
    end

    // R2: lock flag is sticky outside power-on reset
    p_lock_hold_r2: assert property (@(posedge clk_i) disable iff (por_i)
        lock_flag_o |=> lock_flag_o);

    // R3: low-voltage reset sets the flag
    p_lvd_set_r3: assert property (@(posedge clk_i) disable iff (por_i)
        (kind_i == RST_SYS_LVD) |=> lvd_flag_o);

    // R3: other system resets keep the flag
    p_lvd_keep_r3: assert property (@(posedge clk_i) disable iff (por_i)
        (kind_i == RST_SYS_OTHER && lvd_flag_o) |=> lvd_flag_o);

    // R6: enable follows written data
    p_en_write_r6: assert property (@(posedge clk_i) disable iff (por_i)
        (kind_i == RST_NONE && wr_i.hit) |=> (irq_en_o == $past(wr_i.ien_bit)));
endmodule

// File: rtl/ssr_irq_ctrl.sv
module ssr_irq_ctrl
    import ssr_pkg::*;
(
    input  logic      clk_i,
    input  logic      por_i,
    input  rst_kind_e kind_i,
    input  logic      vdet_s_i,
    input  logic      irq_en_i,
    input  logic      ack_i,
    output logic      pending_o
);
    logic vdet_prev;
    logic rise;

    assign rise = vdet_s_i & ~vdet_prev;

    always_ff @(posedge clk_i) begin
        if (por_i) vdet_prev <= 1'b0;
        else       vdet_prev <= vdet_s_i;
    end

    always_ff @(posedge clk_i) begin
        if (kind_i != RST_NONE)      pending_o <= 1'b0;
        else if (rise && irq_en_i)   pending_o <= 1'b1;
        else if (ack_i)              pending_o <= 1'b0;
    end

    // R7: enabled rising edge raises the request
    p_irq_set_r7: assert property (@(posedge clk_i) disable iff (por_i)
        (kind_i == RST_NONE && rise && irq_en_i) |=> pending_o);

    // R8: acknowledge without a competing edge clears the request
    p_ack_clear_r8: assert property (@(posedge clk_i) disable iff (por_i)
        (kind_i == RST_NONE && ack_i && !(rise && irq_en_i)) |=> !pending_o);

    // R9: any system reset drops the request
    p_sysrst_clear_r9: assert property (@(posedge clk_i) disable iff (por_i)
        (kind_i != RST_NONE) |=> !pending_o);
endmodule

// File: rtl/supply_status_reg.sv
module supply_status_reg
    import ssr_pkg::*;
(
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              sys_rst_i,
    input  logic              rst_lvd_cause_i,
    input  logic              pll_lock_raw_i,
    input  logic              vdet_low_raw_i,
    input  logic              irq_ack_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    output logic [BUS_DW-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int unsigned N_SYNC = 2;

    rst_kind_e         kind;
    logic [N_SYNC-1:0] raw_vec;
    logic [N_SYNC-1:0] sync_vec;
    logic              addr_hit;
    wr_req_t           wr;
    status_t           stat;
    logic              lock_flag, lvd_flag, irq_en, pending;
    logic              unused_wdata;

    assign kind    = classify_reset(por_i, sys_rst_i, rst_lvd_cause_i);
    assign raw_vec = {pll_lock_raw_i, vdet_low_raw_i};

    ssr_sync_bank #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (por_i),
        .d_i   (raw_vec),
        .q_o   (sync_vec)
    );

    assign addr_hit   = bus_sel_i && (bus_addr_i == STATUS_ADDR);
    assign wr.hit     = addr_hit && bus_wr_i;
    assign wr.lvd_bit = bus_wdata_i[BIT_LVD];
    assign wr.ien_bit = bus_wdata_i[BIT_IEN];
    assign unused_wdata = ^{bus_wdata_i[7:3], bus_wdata_i[1]};

    ssr_flag_bank u_flags (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .kind_i      (kind),
        .lock_s_i    (sync_vec[1]),
        .wr_i        (wr),
        .lock_flag_o (lock_flag),
        .lvd_flag_o  (lvd_flag),
        .irq_en_o    (irq_en)
    );

    ssr_irq_ctrl u_irq (
        .clk_i     (clk_i),
        .por_i     (por_i),
        .kind_i    (kind),
        .vdet_s_i  (sync_vec[0]),
        .irq_en_i  (irq_en),
        .ack_i     (irq_ack_i),
        .pending_o (pending)
    );

    always_comb begin
        stat          = '0;
        stat.pll_lock = lock_flag;
        stat.lvd_rst  = lvd_flag;
        stat.vdet_low = sync_vec[0];
        stat.irq_en   = irq_en;
    end

    assign bus_rdata_o = addr_hit ? status_to_byte(stat) : '0;
    assign irq_o       = pending;

    // R11: power-on reset leaves everything clear on the next edge
    p_por_clear_r11: assert property (@(posedge clk_i)
        por_i |=> (!irq_o && !lock_flag && !lvd_flag && !irq_en));

    // R10: an unaddressed read returns zero
    p_miss_zero_r10: assert property (@(posedge clk_i) disable iff (por_i)
        (!bus_sel_i || bus_addr_i != STATUS_ADDR) |-> (bus_rdata_o == '0));
endmodule

// File: tb/supply_status_reg_tb_top.sv
`timescale 1ns/1ps
module supply_status_reg_tb_top;
    logic       clk = 1'b0;
    logic       por = 1'b1, sys_rst = 1'b0, lvd_cause = 1'b0;
    logic       lock_raw = 1'b0, vdet_raw = 1'b0, ack = 1'b0;
    logic       sel = 1'b0, wr = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    supply_status_reg dut_i (
        .clk_i(clk), .por_i(por), .sys_rst_i(sys_rst), .rst_lvd_cause_i(lvd_cause),
        .pll_lock_raw_i(lock_raw), .vdet_low_raw_i(vdet_raw), .irq_ack_i(ack),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [7:0] exp_byte(input logic lk, input logic lv, input logic vd, input logic en);
        return {4'b0000, lk, lv, vd, en};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        tick(1);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #0.5 d = rdata;
        sel = 1'b0;
    endtask

    task automatic do_sys_reset(input logic cause);
        sys_rst = 1'b1; lvd_cause = cause;
        tick(1);
        sys_rst = 1'b0; lvd_cause = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        logic m_s1, m_s2, m_prev, m_pend, rise;
        void'($urandom(32'd1357));

        // R11: power-on reset
        tick(3);
        por = 1'b0;
        bus_read(8'h3A, r); check("R11 por state", r, 8'h00);
        check("R11 irq after por", {7'b0, irq}, 8'h00);

        // R1 R4 R5: write all ones
        bus_write(8'h3A, 8'hFF);
        bus_read(8'h3A, r); check("R1 R4 R5 write ff", r, exp_byte(0, 0, 0, 1));

        // R10: other address
        bus_write(8'h3B, 8'h00);
        bus_read(8'h3A, r); check("R10 write elsewhere ignored", r, exp_byte(0, 0, 0, 1));
        bus_read(8'h3B, r); check("R10 read elsewhere zero", r, 8'h00);

        // R2: lock latency and stickiness
        lock_raw = 1'b1;
        tick(2);
        bus_read(8'h3A, r); check("R2 lock not before third edge", r, exp_byte(0, 0, 0, 1));
        tick(1);
        bus_read(8'h3A, r); check("R2 lock on third edge", r, exp_byte(1, 0, 0, 1));
        lock_raw = 1'b0;
        tick(4);
        bus_write(8'h3A, 8'h00);
        bus_read(8'h3A, r); check("R2 lock sticky vs input and write", r, exp_byte(1, 0, 0, 0));

        // R3 R6: low-voltage reset
        bus_write(8'h3A, 8'h01);
        do_sys_reset(1'b1);
        bus_read(8'h3A, r); check("R3 R6 lvd reset", r, exp_byte(1, 1, 0, 0));
        // R3: watchdog-like and external-like resets keep it
        do_sys_reset(1'b0);
        bus_read(8'h3A, r); check("R3 kept across second reset", r, exp_byte(1, 1, 0, 0));
        tick(2);
        do_sys_reset(1'b0);
        bus_read(8'h3A, r); check("R3 R2 kept across third reset", r, exp_byte(1, 1, 0, 0));

        // R4: write 1 keeps, write 0 clears
        bus_write(8'h3A, 8'h04);
        bus_read(8'h3A, r); check("R4 write one keeps", r, exp_byte(1, 1, 0, 0));
        bus_write(8'h3A, 8'h00);
        bus_read(8'h3A, r); check("R4 write zero clears", r, exp_byte(1, 0, 0, 0));

        // R5: comparator latency
        vdet_raw = 1'b1;
        tick(1);
        bus_read(8'h3A, r); check("R5 vdet after one edge", r, exp_byte(1, 0, 0, 0));
        tick(1);
        bus_read(8'h3A, r); check("R5 vdet after two edges", r, exp_byte(1, 0, 1, 0));
        bus_write(8'h3A, 8'h00);
        bus_read(8'h3A, r); check("R5 vdet read only", r, exp_byte(1, 0, 1, 0));
        vdet_raw = 1'b0;
        tick(4);

        // R7: disabled -> no request
        vdet_raw = 1'b1; tick(4);
        check("R7 disabled no irq", {7'b0, irq}, 8'h00);
        vdet_raw = 1'b0; tick(4);

        // R7 R8: enabled request and acknowledge
        bus_write(8'h3A, 8'h01);
        vdet_raw = 1'b1;
        tick(2);
        check("R7 irq not before third edge", {7'b0, irq}, 8'h00);
        tick(1);
        check("R7 irq on third edge", {7'b0, irq}, 8'h01);
        ack = 1'b1; tick(1); ack = 1'b0;
        check("R8 ack clears", {7'b0, irq}, 8'h00);

        // R8: ack coinciding with new edge
        vdet_raw = 1'b0; tick(4);
        vdet_raw = 1'b1; tick(3);
        check("R8 setup pending", {7'b0, irq}, 8'h01);
        vdet_raw = 1'b0; tick(4);
        vdet_raw = 1'b1; tick(2);
        ack = 1'b1; tick(1); ack = 1'b0;
        check("R8 edge wins over ack", {7'b0, irq}, 8'h01);
        ack = 1'b1; tick(1); ack = 1'b0;
        check("R8 later ack clears", {7'b0, irq}, 8'h00);

        // R9: system reset drops request
        vdet_raw = 1'b0; tick(4);
        vdet_raw = 1'b1; tick(3);
        check("R9 setup pending", {7'b0, irq}, 8'h01);
        do_sys_reset(1'b0);
        check("R9 sys reset clears irq", {7'b0, irq}, 8'h00);
        bus_read(8'h3A, r); check("R9 R6 enable cleared", r, exp_byte(1, 0, 1, 0));

        // R11: power-on clears everything
        do_sys_reset(1'b1);
        por = 1'b1; tick(1); por = 1'b0;
        vdet_raw = 1'b0;
        bus_read(8'h3A, r); check("R11 por clears lock and lvd", r, 8'h00);

        // random phase R5 R7 R8
        tick(4);
        bus_write(8'h3A, 8'h01);
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
        sel = 1'b1; wr = 1'b0; addr = 8'h3A;
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 3 == 0) vdet_raw = ~vdet_raw;
            ack = ($urandom % 4 == 0);
            @(posedge clk);
            rise = m_s2 & ~m_prev;
            if (rise) m_pend = 1'b1;
            else if (ack) m_pend = 1'b0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = vdet_raw;
            @(negedge clk);
            check("R5 random vdet bit", {7'b0, rdata[1]}, {7'b0, m_s2});
            check("R7 R8 random irq", {7'b0, irq}, {7'b0, m_pend});
        end
        sel = 1'b0; ack = 1'b0;
        tick(2);
        finish_run();
    end
endmodule